// File: doc/BRIEF.md
# Telemetry Scan and Alarm Unit

This unit steps an external multichannel converter through a fixed list of measurement channels without any host command. Each channel gets a fixed time slot. At the start of the slot the unit selects the channel and pulses a start request. When the converter answers with a done strobe inside that slot, the 14-bit result goes into that channel's result register, and the same value is compared against two programmable limits for the channel.

A crossing of a limit sets a sticky flag bit. The host clears a flag by writing a one to that bit. The alarm output is high while any flag is set whose enable bit is also set. All enables come out of reset cleared, with one exception: the high-limit enable of the die temperature channel starts out set. A temperature reading above its programmed limit therefore raises the alarm with no setup. The host reaches every register through a word port with 8-bit addresses and 16-bit data. Read data is registered.

Address layout: bits 7:4 select a group and bits 3:0 select the channel or control word. Group 0x0 holds the results (read only). Group 0x1 holds the high limits and group 0x2 the low limits. Group 0x3 holds the control words: 0x30 high enables, 0x31 low enables, 0x32 high flags, 0x33 low flags. Bit n of each control word belongs to channel n.

Top module: `telem_scan_unit`

## Requirements
- R1: After reset the unit issues `conv_start` with no host action, first for channel 0. Successive starts select channels 0,1,…,10 in order and then wrap to 0.
- R2: Consecutive `conv_start` pulses are exactly SLOT_CYC cycles apart, and each is one cycle wide.
- R3: A `conv_done` seen during a slot stores `conv_data` in that slot's channel result register (address 0x00+n). A read returns the value in bits 13:0, with bits 15:14 zero.
- R4: If no `conv_done` arrives during a slot, that channel's result keeps its previous value and the scan still moves on to the next channel.
- R5: Reset values are: results 0, high limits 0x3FFF, low limits 0, high enables 0x0400 (only channel 10, the die temperature, set), low enables 0, flags 0, and `alarm` low.
- R6: Limit registers read back what was written. A write to a result address has no effect.
- R7: A captured result greater than its high limit sets high flag bit n (0x32). A result less than its low limit sets low flag bit n (0x33). A result equal to a limit sets neither.
- R8: Flags stay set until the host writes a 1 to the bit. Writing 0 leaves the bit unchanged.
- R9: `alarm` is high exactly when some flag is set whose enable bit in 0x30/0x31 is set. A set flag with its enable cleared does not raise `alarm`.
- R10: With reset enables, a die temperature (channel 10) result above its high limit raises `alarm`.
- R11: `reg_rdata` carries the addressed value in the cycle after `reg_rd_en`. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 4 | Channel being measured |
| conv_done | input | 1 | Converter result strobe |
| conv_data | input | 14 | Converter result |
| reg_wr_en | input | 1 | Register word write |
| reg_rd_en | input | 1 | Register word read |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, registered |
| alarm | output | 1 | OR of enabled flags |

## Verification
The hardest case to reach from the ports is a slot in which the converter never answers. The stored result must survive that slot while the scan keeps moving. The bench's converter model has a silent switch. The bench turns it on, changes the values the model would return, waits two full scans, and then confirms that every result still holds its earlier value and that start pulses kept coming. Limit equality is also driven on purpose: one channel returns exactly the reset high limit and another returns exactly a programmed limit, to show that equality sets no flag.

// File: rtl/telem_pkg.sv
// Package: register port widths and address decode codes for the telemetry unit.
// Assumes the address splits into a 4-bit group (upper) and a 4-bit index (lower).
package telem_pkg;
    localparam int REG_DW = 16;
    localparam int REG_AW = 8;

    localparam logic [3:0] GRP_RESULT = 4'h0;
    localparam logic [3:0] GRP_HILIM  = 4'h1;
    localparam logic [3:0] GRP_LOLIM  = 4'h2;
    localparam logic [3:0] GRP_CTRL   = 4'h3;

    localparam logic [3:0] CTL_HI_EN   = 4'h0;
    localparam logic [3:0] CTL_LO_EN   = 4'h1;
    localparam logic [3:0] CTL_HI_FLAG = 4'h2;
    localparam logic [3:0] CTL_LO_FLAG = 4'h3;
endpackage

// File: rtl/telem_sched.sv
// Module: round-robin channel scheduler. Each channel owns a slot of SLOT_CYC
// cycles. A start pulse opens the slot, and a done strobe inside the slot is
// passed on as a capture. Assumes SLOT_CYC >= 2 and NUM_CH >= 2.
module telem_sched #(
    parameter int NUM_CH   = 11,
    parameter int RES_W    = 14,
    parameter int SLOT_CYC = 82000,
    parameter int CH_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_chan,
    output logic             cap_valid,
    output logic [CH_W-1:0]  cap_chan,
    output logic [RES_W-1:0] cap_data
);
    localparam int CNT_W = (SLOT_CYC > 2) ? $clog2(SLOT_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOT_CYC - 1);
    localparam logic [CH_W-1:0]  CH_LAST  = CH_W'(NUM_CH - 1);

    logic             run_q;
    logic             pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CH_W-1:0]  chan_q;
    logic             slot_end;

    assign slot_end   = run_q && (cnt_q == CNT_LAST);
    assign conv_start = run_q && (cnt_q == '0);
    assign conv_chan  = chan_q;
    assign cap_valid  = pend_q && conv_done;
    assign cap_chan   = chan_q;
    assign cap_data   = conv_data;

    // Slot timer and channel pointer, advancing once per slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            cnt_q  <= '0;
            chan_q <= '0;
        end else begin
            run_q <= 1'b1;
            if (run_q) begin
                if (slot_end) begin
                    cnt_q  <= '0;
                    chan_q <= (chan_q == CH_LAST) ? '0 : chan_q + 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // Pending flag: a result is accepted only between start and slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (conv_start) begin
            pend_q <= 1'b1;
        end else if (cap_valid || slot_end) begin
            pend_q <= 1'b0;
        end
    end

    assert_start_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (conv_chan <= CH_LAST));

    assert_chan_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end |=> (conv_start &&
            (conv_chan == (($past(conv_chan) == CH_LAST) ? '0 : $past(conv_chan) + 1'b1))));

    assert_start_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
endmodule

// File: rtl/telem_regbank.sv
// Module: per-channel result registers and limit registers. A result is loaded
// whole in one cycle from a capture, so a read never sees a partial value.
// Limits are written through the decoded register port.
module telem_regbank
    import telem_pkg::*;
#(
    parameter int NUM_CH = 11,
    parameter int RES_W  = 14,
    parameter int CH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_valid,
    input  logic [CH_W-1:0]   cap_chan,
    input  logic [RES_W-1:0]  cap_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_grp,
    input  logic [3:0]        wr_idx,
    input  logic [REG_DW-1:0] wdata,
    output logic [RES_W-1:0]  result_o [NUM_CH],
    output logic [REG_DW-1:0] hi_lim_o [NUM_CH],
    output logic [REG_DW-1:0] lo_lim_o [NUM_CH]
);
    localparam logic [REG_DW-1:0] HI_RST = REG_DW'({RES_W{1'b1}});

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic hit_cap, hit_hi, hit_lo;
        assign hit_cap = cap_valid && (cap_chan == CH_W'(g));
        assign hit_hi  = wr_en && (wr_grp == GRP_HILIM) && (wr_idx == 4'(g));
        assign hit_lo  = wr_en && (wr_grp == GRP_LOLIM) && (wr_idx == 4'(g));

        // Result register: loaded only by a capture for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)       result_o[g] <= '0;
            else if (hit_cap) result_o[g] <= cap_data;
        end

        // Limit registers: host-written, reset to the full-scale window.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_lim_o[g] <= HI_RST;
                lo_lim_o[g] <= '0;
            end else begin
                if (hit_hi) hi_lim_o[g] <= wdata;
                if (hit_lo) lo_lim_o[g] <= wdata;
            end
        end

        assert_result_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_valid && (cap_chan == CH_W'(g))) |=> (result_o[g] == $past(cap_data)));

        assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !(cap_valid && (cap_chan == CH_W'(g))) |=> $stable(result_o[g]));
    end
endmodule

// File: rtl/telem_alarm.sv
// Module: limit comparison, sticky high/low flags with write-one-to-clear, the
// enable registers and the alarm output. A set from a capture wins over a clear
// in the same cycle. Assumes NUM_CH <= 16 and DIE_CH < NUM_CH.
module telem_alarm
    import telem_pkg::*;
#(
    parameter int NUM_CH = 11,
    parameter int RES_W  = 14,
    parameter int CH_W   = 4,
    parameter int DIE_CH = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_valid,
    input  logic [CH_W-1:0]   cap_chan,
    input  logic [RES_W-1:0]  cap_data,
    input  logic [REG_DW-1:0] hi_lim_i [NUM_CH],
    input  logic [REG_DW-1:0] lo_lim_i [NUM_CH],
    input  logic              wr_en,
    input  logic [3:0]        wr_grp,
    input  logic [3:0]        wr_idx,
    input  logic [NUM_CH-1:0] wbits,
    output logic [NUM_CH-1:0] hi_en_o,
    output logic [NUM_CH-1:0] lo_en_o,
    output logic [NUM_CH-1:0] hi_flag_o,
    output logic [NUM_CH-1:0] lo_flag_o,
    output logic              alarm
);
    localparam logic [NUM_CH-1:0] HI_EN_RST = NUM_CH'(1) << DIE_CH;

    logic [REG_DW-1:0] val_ext;
    logic              over, under, ctl_wr, en_wr;
    logic [NUM_CH-1:0] onehot, hi_set, lo_set, hi_clr, lo_clr;

    // Compare the captured value with its channel's limits and build set/clear masks.
    always_comb begin
        val_ext = REG_DW'(cap_data);
        over    = val_ext > hi_lim_i[cap_chan];
        under   = val_ext < lo_lim_i[cap_chan];
        onehot  = NUM_CH'(1) << cap_chan;
        hi_set  = (cap_valid && over)  ? onehot : '0;
        lo_set  = (cap_valid && under) ? onehot : '0;
        ctl_wr  = wr_en && (wr_grp == GRP_CTRL);
        en_wr   = ctl_wr && ((wr_idx == CTL_HI_EN) || (wr_idx == CTL_LO_EN));
        hi_clr  = (ctl_wr && (wr_idx == CTL_HI_FLAG)) ? wbits : '0;
        lo_clr  = (ctl_wr && (wr_idx == CTL_LO_FLAG)) ? wbits : '0;
    end

    // Enable registers: only the die temperature high enable starts set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_en_o <= HI_EN_RST;
            lo_en_o <= '0;
        end else begin
            if (ctl_wr && (wr_idx == CTL_HI_EN)) hi_en_o <= wbits;
            if (ctl_wr && (wr_idx == CTL_LO_EN)) lo_en_o <= wbits;
        end
    end

    // Sticky flags: cleared by writing ones, set by limit crossings (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_flag_o <= '0;
            lo_flag_o <= '0;
        end else begin
            hi_flag_o <= (hi_flag_o & ~hi_clr) | hi_set;
            lo_flag_o <= (lo_flag_o & ~lo_clr) | lo_set;
        end
    end

    assign alarm = |((hi_flag_o & hi_en_o) | (lo_flag_o & lo_en_o));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_clr == '0) |=> ((hi_flag_o & $past(hi_flag_o)) == $past(hi_flag_o)));

    assert_flag_needs_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_valid |=> ((hi_flag_o & ~$past(hi_flag_o)) == '0) &&
                       ((lo_flag_o & ~$past(lo_flag_o)) == '0));

    assert_alarm_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> ($past(cap_valid) || $past(en_wr)));
endmodule

// File: rtl/telem_scan_unit.sv
// Module: top of the telemetry scan and alarm unit. Ties the scheduler, the
// register bank and the alarm logic together and provides the registered
// read mux of the word register port. Assumes NUM_CH <= 16 and RES_W <= 16.
module telem_scan_unit
    import telem_pkg::*;
#(
    parameter int NUM_CH   = 11,
    parameter int RES_W    = 14,
    parameter int SLOT_CYC = 82000,
    parameter int DIE_CH   = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    output logic                       conv_start,
    output logic [$clog2(NUM_CH)-1:0]  conv_chan,
    input  logic                       conv_done,
    input  logic [RES_W-1:0]           conv_data,
    input  logic                       reg_wr_en,
    input  logic                       reg_rd_en,
    input  logic [REG_AW-1:0]          reg_addr,
    input  logic [REG_DW-1:0]          reg_wdata,
    output logic [REG_DW-1:0]          reg_rdata,
    output logic                       alarm
);
    localparam int CH_W = $clog2(NUM_CH);

    logic              cap_valid;
    logic [CH_W-1:0]   cap_chan;
    logic [RES_W-1:0]  cap_data;
    logic [3:0]        grp, idx;
    logic [RES_W-1:0]  result [NUM_CH];
    logic [REG_DW-1:0] hi_lim [NUM_CH];
    logic [REG_DW-1:0] lo_lim [NUM_CH];
    logic [NUM_CH-1:0] hi_en, lo_en, hi_flag, lo_flag;
    logic [REG_DW-1:0] rd_mux;
    logic              idx_ok;

    assign grp    = reg_addr[7:4];
    assign idx    = reg_addr[3:0];
    assign idx_ok = (32'(idx) < NUM_CH);

    telem_sched #(.NUM_CH(NUM_CH), .RES_W(RES_W), .SLOT_CYC(SLOT_CYC), .CH_W(CH_W)) u_sched (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
        .conv_start(conv_start), .conv_chan(conv_chan),
        .cap_valid(cap_valid), .cap_chan(cap_chan), .cap_data(cap_data)
    );

    telem_regbank #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_chan(cap_chan),
        .cap_data(cap_data), .wr_en(reg_wr_en), .wr_grp(grp), .wr_idx(idx),
        .wdata(reg_wdata), .result_o(result), .hi_lim_o(hi_lim), .lo_lim_o(lo_lim)
    );

    telem_alarm #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W), .DIE_CH(DIE_CH)) u_alarm (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_chan(cap_chan),
        .cap_data(cap_data), .hi_lim_i(hi_lim), .lo_lim_i(lo_lim),
        .wr_en(reg_wr_en), .wr_grp(grp), .wr_idx(idx), .wbits(reg_wdata[NUM_CH-1:0]),
        .hi_en_o(hi_en), .lo_en_o(lo_en), .hi_flag_o(hi_flag), .lo_flag_o(lo_flag),
        .alarm(alarm)
    );

    // Read mux: select the addressed word, zero for unmapped addresses.
    always_comb begin
        rd_mux = '0;
        case (grp)
            GRP_RESULT: if (idx_ok) rd_mux = REG_DW'(result[idx]);
            GRP_HILIM:  if (idx_ok) rd_mux = hi_lim[idx];
            GRP_LOLIM:  if (idx_ok) rd_mux = lo_lim[idx];
            GRP_CTRL: begin
                case (idx)
                    CTL_HI_EN:   rd_mux = REG_DW'(hi_en);
                    CTL_LO_EN:   rd_mux = REG_DW'(lo_en);
                    CTL_HI_FLAG: rd_mux = REG_DW'(hi_flag);
                    CTL_LO_FLAG: rd_mux = REG_DW'(lo_flag);
                    default:     rd_mux = '0;
                endcase
            end
            default: rd_mux = '0;
        endcase
    end

    // Read data register: loads the addressed word whenever a read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n)         reg_rdata <= '0;
        else if (reg_rd_en) reg_rdata <= rd_mux;
    end

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> $stable(reg_rdata));
endmodule

// File: tb/telem_scan_unit_tb.sv
module telem_scan_unit_tb;
    localparam int NCH  = 11;
    localparam int SLOT = 16;
    localparam int LAT  = 3;
    localparam int SCAN = NCH * SLOT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_start;
    logic [3:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [13:0] conv_data = '0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic        alarm;

    always #5 clk = ~clk;

    telem_scan_unit #(.NUM_CH(NCH), .RES_W(14), .SLOT_CYC(SLOT), .DIE_CH(10)) u_dut (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_chan(conv_chan),
        .conv_done(conv_done), .conv_data(conv_data), .reg_wr_en(reg_wr_en),
        .reg_rd_en(reg_rd_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .alarm(alarm)
    );

    int errors = 0, checks = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [13:0] conv_val [NCH];
    bit   silent = 1'b0;
    int   log_ch [256];
    longint log_t [256];
    int   nlog = 0;

    // Converter model: answers each start after LAT cycles unless silent.
    initial begin
        bit pend = 1'b0;
        int lcnt = 0;
        int lch = 0;
        forever begin
            @(negedge clk);
            if (conv_done) conv_done = 1'b0;
            if (conv_start) begin
                if (nlog < 256) begin
                    log_ch[nlog] = int'(conv_chan);
                    log_t[nlog] = cyc;
                    nlog++;
                end
                if (!silent) begin
                    pend = 1'b1; lcnt = LAT; lch = int'(conv_chan);
                end
            end else if (pend) begin
                lcnt--;
                if (lcnt == 0) begin
                    conv_done = 1'b1;
                    conv_data = conv_val[lch];
                    pend = 1'b0;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd_en = 1'b1;
        @(negedge clk);
        reg_rd_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic wait_scans(input int n);
        repeat (n * SCAN + SLOT) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        nlog = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk("R5 alarm after reset", alarm, 0);
        rd(8'h10, d); chk("R5 high limit reset", d, 16'h3FFF);
        rd(8'h25, d); chk("R5 low limit reset", d, 0);
        rd(8'h30, d); chk("R5 high enables reset", d, 16'h0400);
        rd(8'h31, d); chk("R5 low enables reset", d, 0);
        rd(8'h32, d); chk("R5 high flags reset", d, 0);
        rd(8'h33, d); chk("R5 low flags reset", d, 0);
        rd(8'h0A, d); chk("R5 result reset", d, 0);
        chk("R1 first channel is 0", 16'(log_ch[0]), 0);
    endtask

    task automatic t_order;
        nlog = 0;
        while (nlog < 13) @(negedge clk);
        for (int i = 0; i < 12; i++) begin
            chk("R1 channel order", 16'(log_ch[i+1]), 16'((log_ch[i] + 1) % NCH));
            chk("R2 start spacing", 16'(log_t[i+1] - log_t[i]), 16'(SLOT));
        end
    endtask

    task automatic t_results;
        logic [15:0] d;
        for (int i = 0; i < NCH; i++) conv_val[i] = 14'h0100 + 14'(i * 'h111);
        conv_val[0] = 14'h3FFF;
        wait_scans(2);
        for (int i = 0; i < NCH; i++) begin
            rd(8'(i), d); chk("R3 result readback", d, 16'(conv_val[i]));
        end
        rd(8'h32, d); chk("R7 equal to reset high limit sets no flag", d, 0);
    endtask

    task automatic t_dietemp;
        logic [15:0] d;
        wr(8'h1A, 16'h2000);
        conv_val[10] = 14'h2001;
        wait_scans(2);
        chk("R10 die temperature alarm by default", alarm, 1);
        rd(8'h32, d); chk("R7 die temperature high flag", d, 16'h0400);
        conv_val[10] = 14'h0100;
        wait_scans(2);
        wr(8'h32, 16'h0400);
        rd(8'h32, d); chk("R8 write one clears flag", d, 0);
        chk("R9 alarm drops after clear", alarm, 0);
    endtask

    task automatic t_limits;
        logic [15:0] d;
        wr(8'h13, 16'h0100);
        rd(8'h13, d); chk("R6 high limit readback", d, 16'h0100);
        wr(8'h24, 16'h0050);
        rd(8'h24, d); chk("R6 low limit readback", d, 16'h0050);
        wr(8'h03, 16'hBEEF);
        rd(8'h03, d); chk("R6 result write ignored", d, 16'(conv_val[3]));
    endtask

    task automatic t_compare;
        logic [15:0] d;
        conv_val[3] = 14'h0100;
        conv_val[4] = 14'h004F;
        wait_scans(2);
        rd(8'h32, d); chk("R7 equal to high limit sets no flag", d, 0);
        rd(8'h33, d); chk("R7 below low limit sets flag", d, 16'h0010);
        chk("R9 disabled low flag gives no alarm", alarm, 0);
        conv_val[3] = 14'h0101;
        wait_scans(2);
        rd(8'h32, d); chk("R7 above high limit sets flag", d, 16'h0008);
        chk("R9 disabled high flag gives no alarm", alarm, 0);
        wr(8'h30, 16'h0408);
        chk("R9 enabling set flag raises alarm", alarm, 1);
    endtask

    task automatic t_sticky;
        logic [15:0] d;
        conv_val[3] = 14'h0020;
        wait_scans(2);
        rd(8'h32, d); chk("R8 flag stays after value returns", d, 16'h0008);
        wr(8'h32, 16'h0000);
        rd(8'h32, d); chk("R8 write zero keeps flag", d, 16'h0008);
        chk("R9 alarm held by sticky flag", alarm, 1);
        wr(8'h32, 16'h0008);
        rd(8'h32, d); chk("R8 write one clears flag", d, 0);
        chk("R9 alarm low with only disabled flags", alarm, 0);
    endtask

    task automatic t_noresp;
        logic [15:0] d;
        logic [13:0] old [NCH];
        silent = 1'b1;
        repeat (2 * SLOT) @(negedge clk);
        for (int i = 0; i < NCH; i++) begin
            old[i] = conv_val[i];
            conv_val[i] = ~conv_val[i];
        end
        nlog = 0;
        wait_scans(2);
        for (int i = 0; i < NCH; i++) begin
            rd(8'(i), d); chk("R4 result held without done", d, 16'(old[i]));
        end
        chk("R4 scan continues without done", 16'(nlog >= 2 * NCH), 1);
        silent = 1'b0;
    endtask

    task automatic t_unmapped;
        logic [15:0] d;
        rd(8'h7F, d); chk("R11 unmapped group reads zero", d, 0);
        rd(8'h0B, d); chk("R11 index beyond channels reads zero", d, 0);
        rd(8'h34, d); chk("R11 unused control word reads zero", d, 0);
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) conv_val[i] = 14'(i + 1);
        t_reset();
        t_order();
        t_results();
        t_dietemp();
        t_limits();
        t_compare();
        t_sticky();
        t_noresp();
        t_unmapped();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule